// File: doc/BRIEF.md
# PPS Interval Counter with Slip-Pattern Phase Tracking

This block timestamps the rising edges of a one-pulse-per-second input against a free-running counter clocked by the local reference oscillator (nominally 10 MHz, so one count is 100 ns). For every pair of consecutive pulses it reports the measured interval as a signed deviation from the nominal count, after adding an optional per-pulse correction word supplied by the timing receiver. An external disciplining loop uses these deviations to coarse-steer the oscillator.

When the deviation has settled to within one count and the loop asks for it, the block moves into a phase-tracking mode. The loop then deliberately offsets the reference by +1/N Hz, so one interval in every N reads one count high. The block first waits for that extra count, which marks the point where the reference edge and the pulse edge almost coincide. It then keeps a modulo-N index of the pulses and flags every interval in which the extra count comes early, comes late, is missing, or has the wrong size. This gives roughly N times finer phase knowledge than a single count and lets the loop slew the reference gently.

The pulse input is asynchronous. It is brought into the reference domain through a two-flop synchronizer followed by a rising-edge detector. A pulse that fails to arrive within one and a half nominal intervals is reported as missing.

Top module: `ppsSlipDetector`

## Requirements
- R1: During and right after reset, measValid, slipFlag, rangeFlag and missFlag are 0, devOut and phaseIdx are 0, and modeOut is 0 (frequency mode). The mode encodings are 0 = frequency, 1 = acquiring, 2 = tracking.
- R2: The first pulse edge after reset, or after a missing pulse, only arms the block. Every later rising edge produces a one-cycle measValid with devOut = (reference cycles between the two edges) + sawCorr − NOMINAL.
- R3: sawCorr is a signed two's-complement count correction. It is sampled together with the edge that ends the interval and is added to that interval.
- R4: If devOut is greater than +RANGE_LIM or less than −RANGE_LIM (default 8), the same sample raises rangeFlag, returns the block to frequency mode with phaseIdx 0, and does not raise slipFlag. Values of exactly ±RANGE_LIM are in range.
- R5: In frequency mode, a sample with phaseReq high and devOut in −1..+1 moves the block to acquiring. In any phase mode, a sample taken with phaseReq low returns it to frequency mode with phaseIdx 0. phaseIdx is 0 in frequency mode.
- R6: While acquiring, the first in-range sample with devOut = +1 enters tracking with phaseIdx 0. No sample taken while acquiring raises slipFlag.
- R7: In tracking, each sample advances phaseIdx modulo N. A +1 sample always realigns phaseIdx to 0. slipFlag is raised when a +1 sample lands on a non-zero position, when a sample other than +1 lands on position 0, or when devOut is not 0 or +1.
- R8: N is slipPeriod (8 bits). Values 0 and 1 are treated as 2.
- R9: If no edge arrives within MISS_LIM = NOMINAL + NOMINAL/2 cycles of an armed capture, missFlag pulses for one cycle and the next edge produces no measValid.
- R10: An edge that arrives exactly MISS_LIM cycles after the previous capture is measured normally and does not raise missFlag.
- R11: measValid goes high three rising clock edges after the one at which ppsIn is first seen high, and only a low-to-high transition of ppsIn counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference oscillator clock |
| rstN | input | 1 | Active-low synchronous reset |
| ppsIn | input | 1 | Asynchronous one-pulse-per-second input |
| phaseReq | input | 1 | Request to enter or remain in the phase modes |
| slipPeriod | input | IDX_W | Pattern length N; values below 2 act as 2 |
| sawCorr | input | CORR_W | Signed per-pulse correction in counts |
| measValid | output | 1 | One-cycle strobe marking a new measurement |
| devOut | output | DEV_W | Signed deviation from NOMINAL |
| phaseIdx | output | IDX_W | Position within the N-interval pattern |
| slipFlag | output | 1 | Pattern departure seen on this sample |
| rangeFlag | output | 1 | Deviation beyond ±RANGE_LIM on this sample |
| missFlag | output | 1 | One-cycle strobe for a missing pulse |
| modeOut | output | 2 | 0 frequency, 1 acquiring, 2 tracking |

## Verification
Two functions can fall in the same cycle: the detected pulse edge and the missing-pulse timeout. The bench provokes this by spacing two pulses exactly MISS_LIM cycles apart. It expects a measured, out-of-range sample and no missFlag. It then moves the gap one cycle longer and expects a missFlag and a silent re-arming edge instead. Around both cases, directed slip patterns and seeded random intervals are compared sample by sample against a reference model in the bench, including the cycle in which each sample appears.

// File: rtl/ppsSlipPkg.sv
package ppsSlipPkg;

  typedef enum logic [1:0] {
    MODE_FREQ  = 2'd0,
    MODE_ACQ   = 2'd1,
    MODE_TRACK = 2'd2
  } trackMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // snapshot the counter and restart the timeout
    logic armed;    // a reference capture exists, timeout may fire
  } pathStrobe_t;

endpackage

// File: rtl/ppsCapturePath.sv
module ppsCapturePath
  import ppsSlipPkg::*;
#(
  parameter int NOMINAL = 10_000_000,
  parameter int CORR_W  = 8,
  parameter int CNT_W   = 25,
  parameter int DEV_W   = 27,
  parameter int MISS_LIM = 15_000_000
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     ppsIn,
  input  logic signed [CORR_W-1:0] sawCorr,
  input  pathStrobe_t              strobe,
  output logic                     ppsEdge,
  output logic signed [DEV_W-1:0]  devNow,
  output logic                     missHit
);

  localparam logic signed [DEV_W-1:0] NOM_S   = DEV_W'(NOMINAL);
  localparam logic [CNT_W-1:0]        LIM_C   = CNT_W'(MISS_LIM);
  localparam logic [CNT_W-1:0]        LIM_M1  = CNT_W'(MISS_LIM - 1);

  logic [2:0]       syncQ;
  logic [CNT_W-1:0] freeCnt;
  logic [CNT_W-1:0] lastCap;
  logic [CNT_W-1:0] watchCnt;
  logic [CNT_W-1:0] interval;
  logic signed [DEV_W-1:0] intervalS;
  logic signed [DEV_W-1:0] corrS;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ    <= '0;
      freeCnt  <= '0;
      lastCap  <= '0;
      watchCnt <= '0;
    end else begin
      syncQ   <= {syncQ[1:0], ppsIn};
      freeCnt <= freeCnt + CNT_W'(1);
      if (strobe.capture) begin
        lastCap  <= freeCnt;
        watchCnt <= '0;
      end else if (watchCnt < LIM_C) begin
        watchCnt <= watchCnt + CNT_W'(1);
      end
    end
  end

  always_comb begin
    ppsEdge   = syncQ[1] & ~syncQ[2];
    interval  = freeCnt - lastCap;
    intervalS = $signed({{(DEV_W-CNT_W){1'b0}}, interval});
    corrS     = $signed({{(DEV_W-CORR_W){sawCorr[CORR_W-1]}}, sawCorr});
    devNow    = intervalS + corrS - NOM_S;
    missHit   = strobe.armed && (watchCnt == LIM_M1);
  end

endmodule

// File: rtl/ppsSlipControl.sv
module ppsSlipControl
  import ppsSlipPkg::*;
#(
  parameter int DEV_W     = 27,
  parameter int IDX_W     = 8,
  parameter int RANGE_LIM = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    ppsEdge,
  input  logic signed [DEV_W-1:0] devNow,
  input  logic                    missHit,
  input  logic                    phaseReq,
  input  logic [IDX_W-1:0]        slipPeriod,
  output pathStrobe_t             strobe,
  output logic                    measValid,
  output logic signed [DEV_W-1:0] devOut,
  output logic [IDX_W-1:0]        phaseIdx,
  output logic                    slipFlag,
  output logic                    rangeFlag,
  output logic                    missFlag,
  output logic [1:0]              modeOut
);

  localparam logic signed [DEV_W-1:0] LIM_HI = DEV_W'(RANGE_LIM);
  localparam logic signed [DEV_W-1:0] LIM_LO = -LIM_HI;
  localparam logic signed [DEV_W-1:0] ONE    = DEV_W'(1);
  localparam logic signed [DEV_W-1:0] NEG1   = -ONE;

  trackMode_e       modeQ, modeNext;
  logic             primed;
  logic             outRange, isPlus, isZero, nearZero;
  logic [IDX_W-1:0] effN, advIdx, idxNext;
  logic [IDX_W:0]   incIdx;
  logic             slipNext;

  always_comb begin
    outRange = (devNow > LIM_HI) || (devNow < LIM_LO);
    isPlus   = (devNow == ONE);
    isZero   = (devNow == '0);
    nearZero = (devNow >= NEG1) && (devNow <= ONE);
    effN     = (slipPeriod < IDX_W'(2)) ? IDX_W'(2) : slipPeriod;
    incIdx   = {1'b0, phaseIdx} + (IDX_W+1)'(1);
    advIdx   = (incIdx >= {1'b0, effN}) ? '0 : incIdx[IDX_W-1:0];

    modeNext = modeQ;
    idxNext  = phaseIdx;
    slipNext = 1'b0;
    if (outRange) begin
      modeNext = MODE_FREQ;
      idxNext  = '0;
    end else if (modeQ == MODE_FREQ) begin
      idxNext = '0;
      if (phaseReq && nearZero) modeNext = MODE_ACQ;
    end else if (!phaseReq) begin
      modeNext = MODE_FREQ;
      idxNext  = '0;
    end else if (modeQ == MODE_ACQ) begin
      if (isPlus) begin
        modeNext = MODE_TRACK;
        idxNext  = '0;
      end
    end else begin
      if (isPlus) begin
        slipNext = (advIdx != '0);
        idxNext  = '0;
      end else begin
        slipNext = !isZero || (advIdx == '0);
        idxNext  = advIdx;
      end
    end

    strobe.capture = ppsEdge;
    strobe.armed   = primed;
    modeOut        = modeQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ     <= MODE_FREQ;
      primed    <= 1'b0;
      measValid <= 1'b0;
      devOut    <= '0;
      phaseIdx  <= '0;
      slipFlag  <= 1'b0;
      rangeFlag <= 1'b0;
      missFlag  <= 1'b0;
    end else begin
      measValid <= 1'b0;
      missFlag  <= 1'b0;
      if (ppsEdge) begin
        primed <= 1'b1;
        if (primed) begin
          measValid <= 1'b1;
          devOut    <= devNow;
          rangeFlag <= outRange;
          slipFlag  <= slipNext;
          modeQ     <= modeNext;
          phaseIdx  <= idxNext;
        end
      end else if (missHit) begin
        primed   <= 1'b0;
        missFlag <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/ppsSlipDetector.sv
module ppsSlipDetector
  import ppsSlipPkg::*;
#(
  parameter int NOMINAL   = 10_000_000,
  parameter int CORR_W    = 8,
  parameter int IDX_W     = 8,
  parameter int RANGE_LIM = 8,
  localparam int CNT_W    = $clog2(2 * NOMINAL + 1),
  localparam int DEV_W    = CNT_W + 2,
  localparam int MISS_LIM = NOMINAL + NOMINAL / 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     ppsIn,
  input  logic                     phaseReq,
  input  logic [IDX_W-1:0]         slipPeriod,
  input  logic signed [CORR_W-1:0] sawCorr,
  output logic                     measValid,
  output logic signed [DEV_W-1:0]  devOut,
  output logic [IDX_W-1:0]         phaseIdx,
  output logic                     slipFlag,
  output logic                     rangeFlag,
  output logic                     missFlag,
  output logic [1:0]               modeOut
);

  pathStrobe_t             strobe;
  logic                    ppsEdge;
  logic                    missHit;
  logic signed [DEV_W-1:0] devNow;

  ppsCapturePath #(
    .NOMINAL(NOMINAL), .CORR_W(CORR_W), .CNT_W(CNT_W),
    .DEV_W(DEV_W), .MISS_LIM(MISS_LIM)
  ) uPath (
    .clk(clk), .rstN(rstN), .ppsIn(ppsIn), .sawCorr(sawCorr),
    .strobe(strobe), .ppsEdge(ppsEdge), .devNow(devNow), .missHit(missHit)
  );

  ppsSlipControl #(
    .DEV_W(DEV_W), .IDX_W(IDX_W), .RANGE_LIM(RANGE_LIM)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .ppsEdge(ppsEdge), .devNow(devNow),
    .missHit(missHit), .phaseReq(phaseReq), .slipPeriod(slipPeriod),
    .strobe(strobe), .measValid(measValid), .devOut(devOut),
    .phaseIdx(phaseIdx), .slipFlag(slipFlag), .rangeFlag(rangeFlag),
    .missFlag(missFlag), .modeOut(modeOut)
  );

endmodule

// File: rtl/ppsSlipChecks.sv
module ppsSlipChecks #(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             measValid,
  input logic             slipFlag,
  input logic             rangeFlag,
  input logic             missFlag,
  input logic [1:0]       modeOut,
  input logic [IDX_W-1:0] phaseIdx
);

  assert_single_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    measValid |=> !measValid);

  assert_range_exit_R4: assert property (@(posedge clk) disable iff (!rstN)
    rangeFlag |-> (modeOut == 2'd0) && (phaseIdx == '0) && !slipFlag);

  assert_freq_index_R5: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut == 2'd0) |-> (phaseIdx == '0));

  assert_legal_mode_R5: assert property (@(posedge clk) disable iff (!rstN)
    modeOut != 2'd3);

  assert_slip_tracking_R7: assert property (@(posedge clk) disable iff (!rstN)
    slipFlag |-> (modeOut == 2'd2));

  assert_index_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !measValid |-> $stable(phaseIdx));

  assert_miss_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    missFlag |=> !missFlag && !measValid);

  assert_miss_apart_R9: assert property (@(posedge clk) disable iff (!rstN)
    missFlag |-> !measValid);

endmodule

bind ppsSlipDetector ppsSlipChecks #(.IDX_W(IDX_W)) uChecks (
  .clk(clk), .rstN(rstN), .measValid(measValid), .slipFlag(slipFlag),
  .rangeFlag(rangeFlag), .missFlag(missFlag), .modeOut(modeOut),
  .phaseIdx(phaseIdx)
);

// File: tb/ppsSlipDetector_test.sv
module ppsSlipDetector_test;

  localparam int NOM   = 100;
  localparam int LIM   = NOM + NOM / 2;
  localparam int RNG   = 8;
  localparam int DEVW  = $clog2(2 * NOM + 1) + 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ppsIn = 1'b0;
  logic phaseReq = 1'b0;
  logic [7:0] slipPeriod = 8'd4;
  logic signed [7:0] sawCorr = '0;
  logic measValid, slipFlag, rangeFlag, missFlag;
  logic signed [DEVW-1:0] devOut;
  logic [7:0] phaseIdx;
  logic [1:0] modeOut;

  ppsSlipDetector #(.NOMINAL(NOM)) uut (
    .clk(clk), .rstN(rstN), .ppsIn(ppsIn), .phaseReq(phaseReq),
    .slipPeriod(slipPeriod), .sawCorr(sawCorr), .measValid(measValid),
    .devOut(devOut), .phaseIdx(phaseIdx), .slipFlag(slipFlag),
    .rangeFlag(rangeFlag), .missFlag(missFlag), .modeOut(modeOut)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int failures = 0;

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
    $finish;
  end

  // reference model state and expected samples
  int mMode = 0, mIdx = 0, mPrimed = 0;
  int expMiss = 0, gotMiss = 0;
  int nExp = 0, nObs = 0;
  int expDev[512], expIdx[512], expSlip[512], expRange[512], expMode[512], expCyc[512];
  string expTag[512];

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void predict(int g, int c, int r, int n, string tag);
    int dev, effN, adv, slip, rng;
    if (mPrimed != 0 && g > LIM) begin
      expMiss++;
      mPrimed = 0;
    end
    if (mPrimed == 0) begin
      mPrimed = 1;
      return;
    end
    dev  = g + c - NOM;
    rng  = (dev > RNG || dev < -RNG) ? 1 : 0;
    effN = (n < 2) ? 2 : n;
    slip = 0;
    if (rng != 0) begin
      mMode = 0; mIdx = 0;
    end else if (mMode == 0) begin
      mIdx = 0;
      if (r != 0 && dev >= -1 && dev <= 1) mMode = 1;
    end else if (r == 0) begin
      mMode = 0; mIdx = 0;
    end else if (mMode == 1) begin
      if (dev == 1) begin mMode = 2; mIdx = 0; end
    end else begin
      adv = (mIdx + 1 >= effN) ? 0 : mIdx + 1;
      if (dev == 1) begin
        slip = (adv != 0) ? 1 : 0;
        mIdx = 0;
      end else begin
        slip = (dev != 0 || adv == 0) ? 1 : 0;
        mIdx = adv;
      end
    end
    expDev[nExp] = dev; expIdx[nExp] = mIdx; expSlip[nExp] = slip;
    expRange[nExp] = rng; expMode[nExp] = mMode; expCyc[nExp] = cyc + 3;
    expTag[nExp] = tag;
    nExp++;
  endfunction

  task automatic sampleOut();
    if (measValid) begin
      if (nObs >= nExp) begin
        chk(1'b0, "R2 unexpected sample", 1, 0);
      end else begin
        chk(int'(devOut) == expDev[nObs], {expTag[nObs], " R2 deviation"}, int'(devOut), expDev[nObs]);
        chk(cyc == expCyc[nObs], "R11 sample cycle", cyc, expCyc[nObs]);
        chk(int'(rangeFlag) == expRange[nObs], {expTag[nObs], " R4 range"}, int'(rangeFlag), expRange[nObs]);
        chk(int'(modeOut) == expMode[nObs], {expTag[nObs], " R5 mode"}, int'(modeOut), expMode[nObs]);
        chk(int'(phaseIdx) == expIdx[nObs], {expTag[nObs], " R7 index"}, int'(phaseIdx), expIdx[nObs]);
        chk(int'(slipFlag) == expSlip[nObs], {expTag[nObs], " R7 slip"}, int'(slipFlag), expSlip[nObs]);
      end
      nObs++;
    end
    if (missFlag) gotMiss++;
  endtask

  // raise ppsIn gap cycles after the previous raise
  task automatic emit(int gap, int c, int r, int n, string tag);
    for (int k = 1; k <= gap; k++) begin
      @(negedge clk);
      sampleOut();
      if (k == 4) ppsIn = 1'b0;
      if (k == gap) begin
        ppsIn      = 1'b1;
        sawCorr    = 8'(c);
        phaseReq   = (r != 0);
        slipPeriod = 8'(n);
        predict(gap, c, r, n, tag);
      end
    end
  endtask

  initial begin
    int seed;
    int n;
    seed = $urandom(32'd20240725);
    seed = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!measValid && !slipFlag && !rangeFlag && !missFlag, "R1 flags", 1, 0);
    chk(devOut == '0 && phaseIdx == '0 && modeOut == 2'd0, "R1 values", int'(modeOut), 0);
    rstN = 1'b1;

    emit(10, 0, 0, 4, "R2");      // arms only
    // R11: a held-high input gives no further sample
    emit(100, 0, 0, 4, "R11");
    // random frequency-mode intervals with corrections
    for (int i = 0; i < 20; i++) begin
      emit(NOM - 12 + int'($urandom % 25), int'($urandom % 7) - 3, 0, 4, "R3");
    end
    emit(97, 3, 0, 4, "R3");
    emit(108, 0, 0, 4, "R4");
    emit(109, 0, 0, 4, "R4");
    emit(92, 0, 0, 4, "R4");
    emit(91, 0, 0, 4, "R4");
    // acquisition and tracking with N = 4
    emit(100, 0, 1, 4, "R5");
    emit(100, 0, 1, 4, "R6");
    emit(100, 0, 1, 4, "R6");
    emit(101, 0, 1, 4, "R6");
    for (int rep = 0; rep < 2; rep++) begin
      emit(100, 0, 1, 4, "R7");
      emit(100, 0, 1, 4, "R7");
      emit(100, 0, 1, 4, "R7");
      emit(101, 0, 1, 4, "R7");
    end
    emit(100, 0, 1, 4, "R7");   // idx 1
    emit(101, 0, 1, 4, "R7");   // early extra
    for (int i = 0; i < 4; i++) emit(100, 0, 1, 4, "R7");  // missing extra
    emit(99, 0, 1, 4, "R7");    // wrong size
    // seeded random tracking
    n = 2 + int'($urandom % 5);
    for (int i = 0; i < 60; i++) begin
      int g;
      g = NOM + (($urandom % 4) == 0 ? 1 : 0);
      if (($urandom % 11) == 0) g = NOM - 1;
      emit(g, 0, (($urandom % 13) != 0) ? 1 : 0, n, "R7");
    end
    // N below 2 behaves as 2
    emit(120, 0, 1, 0, "R8");
    emit(100, 0, 1, 0, "R8");
    emit(101, 0, 1, 0, "R8");
    for (int i = 0; i < 3; i++) begin
      emit(100, 0, 1, 1, "R8");
      emit(101, 0, 1, 0, "R8");
    end
    emit(100, 0, 0, 4, "R5");
    // coincidence of edge and timeout, then a true miss
    emit(LIM, 0, 0, 4, "R10");
    emit(LIM + 1, 0, 0, 4, "R9");
    emit(100, 0, 0, 4, "R9");
    emit(100, 0, 0, 4, "R9");
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      sampleOut();
    end
    chk(gotMiss == expMiss, "R9 missing-pulse count", gotMiss, expMiss);
    chk(nObs == nExp, "R2 R9 sample count", nObs, nExp);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule